// File: doc/BRIEF.md
# Flash Program/Erase Status Responder

This block is the status-generation part of a small flash device model used to exercise host-side flash controllers. A host starts an embedded word program (address, datum, and an optional buffered-page flag) or an embedded erase (a mask of sectors). While that operation runs, every read returns a status word whose bit 7 tells the host what is happening. Bit 7 depends on the kind of operation, on whether an erase is suspended, on the address being read and on sector protection. When the operation ends, reads return stored data again.

The block does not hold the memory array. Array words arrive on a read-data input from the surrounding model. The block keeps a one-word shadow of the most recently completed program so that the host reads back the true datum. Status bits other than bit 7 are a fixed fill pattern. The program time, the erase time and the brief protected-program window are cycle-count parameters. The protected-erase window is derived from a clock-frequency parameter and a window length in microseconds.

Top module: `flash_status_responder`

## Requirements
- R1: After reset, `busy`, `rd_valid` and `rd_data` are all zero, and a read then returns the array word for the address read.
- R2: An accepted program keeps `busy` high for exactly PROG_CYCLES read cycles. During that time, a read at the program address returns STAT_FILL with bit 7 replaced by the inverse of datum bit 7.
- R3: Once an unprotected program finishes, a read at its address returns the programmed datum, and other addresses return array words.
- R4: While an operation is busy, a read outside its target returns IDLE_FILL (0xDEAD by default).
- R5: For a buffered program, the program address is the last word of its page. A page is the address divided by BUF_WORDS. A read of any other word in that page returns the status word with bit 7 equal to the true datum bit 7.
- R6: A program whose sector is protected shows inverted bit 7 for PROT_PROG_CYCLES cycles and then returns to read mode without storing the datum. A sector is address bits [ADDR_W-1 -: SECT_W], and protection bit n covers sector n.
- R7: An erase returns the status word with bit 7 equal to 0 at addresses in selected, unprotected sectors for ERASE_CYCLES cycles, then returns to read mode. A shadowed datum in an erased sector is dropped.
- R8: When only some selected sectors are protected, the erase keeps its full length. Protected selected sectors read as IDLE_FILL while it runs.
- R9: When every selected sector is protected, bit 7 reads 0 at the selected sectors for CLK_HZ/1e6 × PROT_WIN_US cycles, then the block returns to read mode. A suspend request during this window is ignored.
- R10: A suspend request during an unprotected erase stops it. `busy` falls, reads in the erased sectors return bit 7 = 1, and other sectors return data. Resuming continues the remaining count, so the cycles spent erasing still total ERASE_CYCLES.
- R11: A program started during erase suspend behaves as in R2 and R3, then goes back to the suspended erase.
- R12: A program request made while busy is ignored. An erase request is accepted only when idle and only without a program request in the same cycle. In suspend, a program request takes precedence over a resume request.
- R13: `rd_valid` and `rd_data` update one cycle after `rd_en`. `rd_data` holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_start | input | 1 | Start an embedded program |
| prog_addr | input | ADDR_W | Program word address (last word of page when buffered) |
| prog_data | input | DATA_W | Program datum |
| prog_buffered | input | 1 | Program is the final word of a buffered page |
| erase_start | input | 1 | Start an embedded erase |
| erase_sectors | input | NUM_SECT | Sectors selected for erase |
| suspend_req | input | 1 | Suspend the running erase |
| resume_req | input | 1 | Resume the suspended erase |
| sect_prot | input | NUM_SECT | Per-sector protection |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read word address |
| array_rd_data | input | DATA_W | Array word for `rd_addr`, from the surrounding model |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | DATA_W | Read result: status, fill or data |
| busy | output | 1 | An embedded operation is running |

## Verification
Programs are run with datum bit 7 set and with it clear, so that the inverted and the true bit 7 give different read values. The reads go to the program address, to another word in the same buffered page, and to a different page, which separates status, stale status and the fill pattern. Erases are run with no protection, partial protection and full protection. This shows the difference between a real erase, the skipping of protected sectors, and the timed window that leaves nothing erased. A suspend with a program nested inside it, followed by a resume, confirms that the busy count is frozen rather than restarted.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_PROG  = 3'd1,
      ST_ERASE = 3'd2,
      ST_SUSP  = 3'd3,
      ST_SPROG = 3'd4
   } fsr_state_e;

   typedef enum logic [1:0] {
      SRC_DATA   = 2'd0,
      SRC_STATUS = 2'd1,
      SRC_FILL   = 2'd2
   } fsr_src_e;
endpackage

// File: rtl/fsr_timer.sv
module fsr_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic             run_i,
   output logic             done_o
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (run_i && (cnt_q != '0)) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   // final busy cycle: the running count is about to leave one
   assign done_o = run_i && (cnt_q == CNT_W'(1));
endmodule

// File: rtl/fsr_sector_map.sv
module fsr_sector_map #(
   parameter int SECT_W = 3,
   localparam int NUM_SECT = 1 << SECT_W
) (
   input  logic [SECT_W-1:0]   sect_i,
   input  logic [NUM_SECT-1:0] mask_i,
   output logic                hit_o
);
   logic [NUM_SECT-1:0] onehot;

   for (genvar s = 0; s < NUM_SECT; s++) begin : g_dec
      assign onehot[s] = (sect_i == SECT_W'(s));
   end

   assign hit_o = |(onehot & mask_i);
endmodule

// File: rtl/fsr_read_path.sv
module fsr_read_path
   import flash_stat_pkg::*;
#(
   parameter int          ADDR_W    = 12,
   parameter int          DATA_W    = 16,
   parameter int          BUF_WORDS = 4,
   parameter logic [15:0] STAT_FILL = 16'h0000,
   parameter logic [15:0] IDLE_FILL = 16'hDEAD
) (
   input  logic              clk,
   input  logic              rst_n,
   input  fsr_state_e        state_i,
   input  logic              rd_en_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   input  logic [DATA_W-1:0] array_data_i,
   input  logic [ADDR_W-1:0] prog_addr_i,
   input  logic              prog_bit7_i,
   input  logic              prog_buf_i,
   input  logic              rd_in_erase_i,
   input  logic              shadow_vld_i,
   input  logic [ADDR_W-1:0] shadow_addr_i,
   input  logic [DATA_W-1:0] shadow_data_i,
   output logic              rd_valid_o,
   output logic [DATA_W-1:0] rd_data_o
);
   localparam int PAGE_SH = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 0;

   logic              page_hit;
   logic              addr_hit;
   logic              shadow_hit;
   logic              stat_bit;
   fsr_src_e          src;
   logic [DATA_W-1:0] data_word;
   logic [DATA_W-1:0] stat_word;
   logic [DATA_W-1:0] next_word;

   if (BUF_WORDS > 1) begin : g_paged
      assign page_hit = prog_buf_i &&
                        (rd_addr_i[ADDR_W-1:PAGE_SH] == prog_addr_i[ADDR_W-1:PAGE_SH]);
   end else begin : g_flat
      logic unused_buf;
      assign unused_buf = prog_buf_i;
      assign page_hit   = 1'b0;
   end

   assign addr_hit   = (rd_addr_i == prog_addr_i);
   assign shadow_hit = shadow_vld_i && (rd_addr_i == shadow_addr_i);
   assign data_word  = shadow_hit ? shadow_data_i : array_data_i;

   always_comb begin
      src      = SRC_DATA;
      stat_bit = 1'b0;
      unique case (state_i)
         ST_PROG, ST_SPROG: begin
            if (addr_hit) begin
               src      = SRC_STATUS;
               stat_bit = ~prog_bit7_i;
            end else if (page_hit) begin
               src      = SRC_STATUS;
               stat_bit = prog_bit7_i;
            end else begin
               src = SRC_FILL;
            end
         end
         ST_ERASE: begin
            src      = rd_in_erase_i ? SRC_STATUS : SRC_FILL;
            stat_bit = 1'b0;
         end
         ST_SUSP: begin
            src      = rd_in_erase_i ? SRC_STATUS : SRC_DATA;
            stat_bit = 1'b1;
         end
         default: src = SRC_DATA;
      endcase
   end

   always_comb begin
      stat_word    = STAT_FILL[DATA_W-1:0];
      stat_word[7] = stat_bit;
   end

   always_comb begin
      unique case (src)
         SRC_STATUS: next_word = stat_word;
         SRC_FILL:   next_word = IDLE_FILL[DATA_W-1:0];
         default:    next_word = data_word;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid_o <= 1'b0;
         rd_data_o  <= '0;
      end else begin
         rd_valid_o <= rd_en_i;
         if (rd_en_i) begin
            rd_data_o <= next_word;
         end
      end
   end
endmodule

// File: rtl/flash_status_responder.sv
module flash_status_responder
   import flash_stat_pkg::*;
#(
   parameter int          ADDR_W           = 12,
   parameter int          DATA_W           = 16,
   parameter int          SECT_W           = 3,
   parameter int          BUF_WORDS        = 4,
   parameter int          CLK_HZ           = 50_000_000,
   parameter int          PROT_WIN_US      = 100,
   parameter int          PROG_CYCLES      = 20,
   parameter int          PROT_PROG_CYCLES = 4,
   parameter int          ERASE_CYCLES     = 200,
   parameter logic [15:0] STAT_FILL        = 16'h0000,
   parameter logic [15:0] IDLE_FILL        = 16'hDEAD,
   localparam int NUM_SECT = 1 << SECT_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                prog_start,
   input  logic [ADDR_W-1:0]   prog_addr,
   input  logic [DATA_W-1:0]   prog_data,
   input  logic                prog_buffered,
   input  logic                erase_start,
   input  logic [NUM_SECT-1:0] erase_sectors,
   input  logic                suspend_req,
   input  logic                resume_req,
   input  logic [NUM_SECT-1:0] sect_prot,
   input  logic                rd_en,
   input  logic [ADDR_W-1:0]   rd_addr,
   input  logic [DATA_W-1:0]   array_rd_data,
   output logic                rd_valid,
   output logic [DATA_W-1:0]   rd_data,
   output logic                busy
);
   localparam int PROT_WIN_CYCLES = (CLK_HZ / 1_000_000) * PROT_WIN_US;
   localparam int PROG_MAX  = (PROG_CYCLES > PROT_PROG_CYCLES) ? PROG_CYCLES : PROT_PROG_CYCLES;
   localparam int ERASE_MAX = (ERASE_CYCLES > PROT_WIN_CYCLES) ? ERASE_CYCLES : PROT_WIN_CYCLES;
   localparam int PCNT_W    = $clog2(PROG_MAX + 1);
   localparam int ECNT_W    = $clog2(ERASE_MAX + 1);

   if (DATA_W < 8 || DATA_W > 16) begin : g_chk_data
      $error("DATA_W must lie in 8..16");
   end
   if (SECT_W < 1 || SECT_W >= ADDR_W) begin : g_chk_sect
      $error("SECT_W must be at least 1 and below ADDR_W");
   end
   if (BUF_WORDS < 1 || (BUF_WORDS & (BUF_WORDS - 1)) != 0) begin : g_chk_buf
      $error("BUF_WORDS must be a power of two");
   end
   if (PROG_CYCLES < 1 || PROT_PROG_CYCLES < 1 || ERASE_CYCLES < 1 || PROT_WIN_CYCLES < 1) begin : g_chk_time
      $error("every busy time must be at least one cycle");
   end

   fsr_state_e          state_q, state_d;
   logic [ADDR_W-1:0]   paddr_q;
   logic [DATA_W-1:0]   pdata_q;
   logic                pbuf_q;
   logic                prog_blk_q;
   logic [NUM_SECT-1:0] erase_sel_q;
   logic [NUM_SECT-1:0] erase_eff_q;
   logic                erase_blk_q;
   logic                shadow_vld_q;
   logic [ADDR_W-1:0]   shadow_addr_q;
   logic [DATA_W-1:0]   shadow_data_q;

   logic                prog_accept;
   logic                erase_accept;
   logic                prog_run;
   logic                prog_done;
   logic                erase_run;
   logic                erase_done;
   logic                go_susp;
   logic                prog_sect_prot;
   logic                shadow_in_erase;
   logic                rd_in_erase;
   logic [NUM_SECT-1:0] erase_target;
   logic [NUM_SECT-1:0] erase_eff_d;
   logic [PCNT_W-1:0]   prog_load_val;
   logic [ECNT_W-1:0]   erase_load_val;

   // ---------------- acceptance ----------------
   assign prog_accept  = prog_start && (state_q == ST_IDLE || state_q == ST_SUSP);
   assign erase_accept = erase_start && !prog_start && (state_q == ST_IDLE);
   assign erase_eff_d  = erase_sectors & ~sect_prot;
   assign go_susp      = (state_q == ST_ERASE) && suspend_req && !erase_blk_q && !erase_done;

   // ---------------- sector lookups ----------------
   fsr_sector_map #(.SECT_W(SECT_W)) u_map_prog (
      .sect_i (prog_addr[ADDR_W-1 -: SECT_W]),
      .mask_i (sect_prot),
      .hit_o  (prog_sect_prot)
   );

   fsr_sector_map #(.SECT_W(SECT_W)) u_map_shadow (
      .sect_i (shadow_addr_q[ADDR_W-1 -: SECT_W]),
      .mask_i (erase_eff_q),
      .hit_o  (shadow_in_erase)
   );

   assign erase_target = erase_blk_q ? erase_sel_q : erase_eff_q;

   fsr_sector_map #(.SECT_W(SECT_W)) u_map_read (
      .sect_i (rd_addr[ADDR_W-1 -: SECT_W]),
      .mask_i (erase_target),
      .hit_o  (rd_in_erase)
   );

   // ---------------- busy timers ----------------
   assign prog_run       = (state_q == ST_PROG) || (state_q == ST_SPROG);
   assign prog_load_val  = prog_sect_prot ? PCNT_W'(PROT_PROG_CYCLES) : PCNT_W'(PROG_CYCLES);
   assign erase_run      = (state_q == ST_ERASE) && !go_susp;
   assign erase_load_val = (erase_eff_d == '0) ? ECNT_W'(PROT_WIN_CYCLES) : ECNT_W'(ERASE_CYCLES);

   fsr_timer #(.CNT_W(PCNT_W)) u_prog_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (prog_accept),
      .load_val_i (prog_load_val),
      .run_i      (prog_run),
      .done_o     (prog_done)
   );

   fsr_timer #(.CNT_W(ECNT_W)) u_erase_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (erase_accept),
      .load_val_i (erase_load_val),
      .run_i      (erase_run),
      .done_o     (erase_done)
   );

   // ---------------- operation state ----------------
   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: begin
            if (prog_start)       state_d = ST_PROG;
            else if (erase_start) state_d = ST_ERASE;
         end
         ST_PROG:  if (prog_done) state_d = ST_IDLE;
         ST_ERASE: begin
            if (erase_done)   state_d = ST_IDLE;
            else if (go_susp) state_d = ST_SUSP;
         end
         ST_SUSP: begin
            if (prog_start)      state_d = ST_SPROG;
            else if (resume_req) state_d = ST_ERASE;
         end
         ST_SPROG: if (prog_done) state_d = ST_SUSP;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
      end else begin
         state_q <= state_d;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         paddr_q    <= '0;
         pdata_q    <= '0;
         pbuf_q     <= 1'b0;
         prog_blk_q <= 1'b0;
      end else if (prog_accept) begin
         paddr_q    <= prog_addr;
         pdata_q    <= prog_data;
         pbuf_q     <= prog_buffered;
         prog_blk_q <= prog_sect_prot;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         erase_sel_q <= '0;
         erase_eff_q <= '0;
         erase_blk_q <= 1'b0;
      end else if (erase_accept) begin
         erase_sel_q <= erase_sectors;
         erase_eff_q <= erase_eff_d;
         erase_blk_q <= (erase_eff_d == '0);
      end
   end

   // one-word shadow of the last completed program
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shadow_vld_q  <= 1'b0;
         shadow_addr_q <= '0;
         shadow_data_q <= '0;
      end else if (prog_done && !prog_blk_q) begin
         shadow_vld_q  <= 1'b1;
         shadow_addr_q <= paddr_q;
         shadow_data_q <= pdata_q;
      end else if (erase_done && !erase_blk_q && shadow_in_erase) begin
         shadow_vld_q  <= 1'b0;
      end
   end

   assign busy = (state_q == ST_PROG) || (state_q == ST_ERASE) || (state_q == ST_SPROG);

   // ---------------- read side ----------------
   fsr_read_path #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .BUF_WORDS (BUF_WORDS),
      .STAT_FILL (STAT_FILL),
      .IDLE_FILL (IDLE_FILL)
   ) u_read (
      .clk           (clk),
      .rst_n         (rst_n),
      .state_i       (state_q),
      .rd_en_i       (rd_en),
      .rd_addr_i     (rd_addr),
      .array_data_i  (array_rd_data),
      .prog_addr_i   (paddr_q),
      .prog_bit7_i   (pdata_q[7]),
      .prog_buf_i    (pbuf_q),
      .rd_in_erase_i (rd_in_erase),
      .shadow_vld_i  (shadow_vld_q),
      .shadow_addr_i (shadow_addr_q),
      .shadow_data_i (shadow_data_q),
      .rd_valid_o    (rd_valid),
      .rd_data_o     (rd_data)
   );
endmodule

// File: rtl/fsr_checker.sv
module fsr_checker
   import flash_stat_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_en,
   input logic              rd_valid,
   input logic [DATA_W-1:0] rd_data,
   input logic              prog_start,
   input logic              suspend_req,
   input logic              busy,
   input fsr_state_e        state_q,
   input logic              erase_blk_q,
   input logic              erase_done
);
   // R13: read result follows the request by one cycle
   a_r13_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> rd_valid);
   a_r13_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !rd_valid);
   a_r13_data_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data));

   // R2 / R11: a program request seen while not busy starts a busy period
   a_r2_prog_goes_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_start && !busy) |=> busy);

   // R10: suspend of an unprotected erase frees the device
   a_r10_suspend_frees: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ERASE && suspend_req && !erase_blk_q && !erase_done)
      |=> (!busy && state_q == ST_SUSP));

   // R9: the all-protected window cannot be suspended
   a_r9_window_not_suspended: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ERASE && erase_blk_q && !erase_done) |=> busy);
endmodule

bind flash_status_responder fsr_checker #(.DATA_W(DATA_W)) u_fsr_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .rd_en       (rd_en),
   .rd_valid    (rd_valid),
   .rd_data     (rd_data),
   .prog_start  (prog_start),
   .suspend_req (suspend_req),
   .busy        (busy),
   .state_q     (state_q),
   .erase_blk_q (erase_blk_q),
   .erase_done  (erase_done)
);

// File: tb/test_flash_status_responder.sv
module test_flash_status_responder;
   localparam int PROG_N  = 20;
   localparam int PPROG_N = 4;
   localparam int ERASE_N = 200;
   localparam int PWIN_N  = 5000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        prog_start = 1'b0;
   logic [11:0] prog_addr = '0;
   logic [15:0] prog_data = '0;
   logic        prog_buffered = 1'b0;
   logic        erase_start = 1'b0;
   logic [7:0]  erase_sectors = '0;
   logic        suspend_req = 1'b0;
   logic        resume_req = 1'b0;
   logic [7:0]  sect_prot = '0;
   logic        rd_en = 1'b0;
   logic [11:0] rd_addr = '0;
   logic [15:0] array_rd_data;
   logic        rd_valid;
   logic [15:0] rd_data;
   logic        busy;

   int n_checks = 0;
   int n_fail   = 0;

   // array model: each word reads as A followed by its address
   assign array_rd_data = {4'hA, rd_addr};

   always #10 clk = ~clk;

   flash_status_responder i_flash_status_responder (
      .clk           (clk),
      .rst_n         (rst_n),
      .prog_start    (prog_start),
      .prog_addr     (prog_addr),
      .prog_data     (prog_data),
      .prog_buffered (prog_buffered),
      .erase_start   (erase_start),
      .erase_sectors (erase_sectors),
      .suspend_req   (suspend_req),
      .resume_req    (resume_req),
      .sect_prot     (sect_prot),
      .rd_en         (rd_en),
      .rd_addr       (rd_addr),
      .array_rd_data (array_rd_data),
      .rd_valid      (rd_valid),
      .rd_data       (rd_data),
      .busy          (busy)
   );

   typedef struct packed {
      logic [7:0]  prot;
      logic        bufd;
      logic [11:0] paddr;
      logic [15:0] pdata;
      logic [11:0] raddr;
      logic [15:0] mid;
      logic [15:0] after;
   } vec_t;

   localparam vec_t VECS [0:5] = '{
      '{8'h00, 1'b0, 12'h123, 16'h00F0, 12'h123, 16'h0000, 16'h00F0}, // R2 R3 bit7 set
      '{8'h00, 1'b0, 12'h123, 16'h1234, 12'h123, 16'h0080, 16'h1234}, // R2 R3 bit7 clear
      '{8'h00, 1'b0, 12'h200, 16'h5555, 12'h300, 16'hDEAD, 16'hA300}, // R4 outside target
      '{8'h00, 1'b1, 12'h407, 16'h00AA, 12'h405, 16'h0080, 16'hA405}, // R5 same page
      '{8'h00, 1'b1, 12'h407, 16'h00AA, 12'h408, 16'hDEAD, 16'hA408}, // R5 other page
      '{8'h01, 1'b0, 12'h050, 16'h0011, 12'h050, 16'h0080, 16'hA050}  // R6 protected
   };

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [11:0] a, output logic [15:0] d);
      rd_en   = 1'b1;
      rd_addr = a;
      @(negedge clk);
      d     = rd_data;
      rd_en = 1'b0;
   endtask

   task automatic start_prog(input logic [11:0] a, input logic [15:0] d, input logic b);
      prog_start    = 1'b1;
      prog_addr     = a;
      prog_data     = d;
      prog_buffered = b;
      @(negedge clk);
      prog_start    = 1'b0;
      prog_buffered = 1'b0;
   endtask

   task automatic start_erase(input logic [7:0] m);
      erase_start   = 1'b1;
      erase_sectors = m;
      @(negedge clk);
      erase_start   = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 10000 && busy; i++) @(negedge clk);
   endtask

   task automatic count_status(input logic [11:0] a, input logic [15:0] st,
                               output int n, output logic [15:0] last);
      logic [15:0] d;
      n = 0;
      for (int i = 0; i < 6000; i++) begin
         rd(a, d);
         if (d !== st) break;
         n++;
      end
      last = d;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      logic [15:0] d;
      int          n;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 busy", {15'd0, busy}, 16'd0);
      check("R1 rd_valid", {15'd0, rd_valid}, 16'd0);
      check("R1 rd_data", rd_data, 16'h0000);
      rd(12'h010, d);
      check("R1 array read", d, 16'hA010);
      check("R13 valid after read", {15'd0, rd_valid}, 16'd1);
      @(negedge clk);
      check("R13 valid drops", {15'd0, rd_valid}, 16'd0);
      check("R13 data holds", rd_data, 16'hA010);

      // table of program scenarios
      foreach (VECS[i]) begin
         sect_prot = VECS[i].prot;
         start_prog(VECS[i].paddr, VECS[i].pdata, VECS[i].bufd);
         rd(VECS[i].raddr, d);
         check($sformatf("R2/R4/R5/R6 vec%0d during", i), d, VECS[i].mid);
         wait_idle();
         rd(VECS[i].raddr, d);
         check($sformatf("R3/R6 vec%0d after", i), d, VECS[i].after);
      end
      sect_prot = 8'h00;

      // R2 exact busy length; R12 erase request while programming is ignored
      start_prog(12'h123, 16'h0080, 1'b0);
      erase_start = 1'b1; erase_sectors = 8'hFF;
      rd(12'h123, d);
      erase_start = 1'b0;
      n = (d === 16'h0000) ? 1 : 0;
      if (d === 16'h0000) begin
         count_status(12'h123, 16'h0000, n, d);
         n = n + 1;
      end
      check("R2 program length", 16'(n), 16'(PROG_N));
      check("R3 datum after program", d, 16'h0080);
      check("R12 erase ignored busy", {15'd0, busy}, 16'd0);
      rd(12'h300, d);
      check("R12 erase ignored data", d, 16'hA300);

      // R7 erase sector 0; R12 program during erase ignored; R4 fill
      start_erase(8'h01);
      prog_start = 1'b1; prog_addr = 12'h700; prog_data = 16'h1111;
      rd(12'h100, d);
      prog_start = 1'b0;
      check("R7 erase status", d, 16'h0000);
      rd(12'h600, d);
      check("R4 erase outside", d, 16'hDEAD);
      count_status(12'h100, 16'h0000, n, d);
      check("R7 erase length", 16'(n + 2), 16'(ERASE_N));
      check("R7 data after erase", d, 16'hA100);
      rd(12'h123, d);
      check("R7 shadow dropped", d, 16'hA123);
      rd(12'h700, d);
      check("R12 program ignored", d, 16'hA700);

      // R8 partial protection
      sect_prot = 8'h04;
      start_erase(8'h06);
      rd(12'h250, d);
      check("R8 unprotected status", d, 16'h0000);
      rd(12'h450, d);
      check("R8 protected fill", d, 16'hDEAD);
      count_status(12'h250, 16'h0000, n, d);
      check("R8 erase length", 16'(n + 2), 16'(ERASE_N));
      check("R8 data after", d, 16'hA250);

      // R9 all selected sectors protected, suspend ignored
      sect_prot = 8'h08;
      start_erase(8'h08);
      n = 0;
      for (int i = 0; i < 6000; i++) begin
         suspend_req = (i == 10);
         rd(12'h650, d);
         suspend_req = 1'b0;
         if (d !== 16'h0000) break;
         n++;
      end
      check("R9 window length", 16'(n), 16'(PWIN_N));
      check("R9 read mode after", d, 16'hA650);
      sect_prot = 8'h00;

      // R10 suspend / R11 program in suspend / resume continues count
      start_erase(8'h10);
      for (int i = 0; i < 50; i++) rd(12'h850, d);
      check("R10 erasing", d, 16'h0000);
      suspend_req = 1'b1;
      @(negedge clk);
      suspend_req = 1'b0;
      check("R10 not busy", {15'd0, busy}, 16'd0);
      rd(12'h850, d);
      check("R10 suspended status", d, 16'h0080);
      rd(12'h100, d);
      check("R10 other sector data", d, 16'hA100);
      resume_req = 1'b1;
      start_prog(12'h010, 16'h00FF, 1'b0);
      resume_req = 1'b0;
      rd(12'h010, d);
      check("R11 program in suspend", d, 16'h0000);
      wait_idle();
      rd(12'h850, d);
      check("R12 back to suspend", d, 16'h0080);
      rd(12'h010, d);
      check("R11 datum after", d, 16'h00FF);
      resume_req = 1'b1;
      @(negedge clk);
      resume_req = 1'b0;
      count_status(12'h850, 16'h0000, n, d);
      check("R10 remaining length", 16'(n), 16'(ERASE_N - 50));
      check("R10 data after", d, 16'hA850);

      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule